// File: doc/BRIEF.md
# Directive-Driven Tile Index Generator for 1-D Convolution

This block walks the tile schedule of a one-dimensional convolution spread over a small array of processing elements. The schedule comes from two loop directives. Each directive names one of the two data dimensions (filter taps or output points) and says whether that dimension is swept in time or split across the processing elements. It also gives how many points each element covers and how far the window moves per step. For every tile the block gives each element its start and end index on the filter and output dimensions. It also gives the matching input range, which is the output range shifted by the filter range.

Software or a sequencer writes the directives, the two dimension lengths and the active element count to the configuration inputs, then pulses `start` while the block is idle. Tiles are then handed out through a valid/ready pair. Each accepted tile advances the loop nest by one position: directive 0 is the outer loop and directive 1 the inner loop. A split-across-elements directive folds over time when its dimension is longer than the elements can cover. One cycle after the final tile is accepted, a single-cycle done flag is raised.

Top module: `maptile_gen`

## Requirements
- R1: While reset is held and on the first cycle after it, `tileValid`, `tileDone` and every bit of `peValid` are low.
- R2: A `start` pulse sampled while idle captures all configuration inputs, and on the next cycle the first tile is presented with both directive bases at 0. A `start` sampled while tiles are being handed out is ignored, together with any change on the configuration inputs. Encodings: bit d of `cfgKind` is 1 for a spatial directive d. Bit d of `cfgDim` is 1 when directive d sweeps the output dimension and 0 for the filter dimension. Directive d's size and offset are at bits `[d*IDX_W +: IDX_W]` of `cfgSize` and `cfgOffset`. The two directives must name different dimensions, sizes and offsets must be at least 1, lengths at least 1, and `cfgPeCount` must lie in 1..NUM_PE.
- R3: For a temporal directive, every element's start index on that directive's dimension equals the directive base. The base grows by the directive offset per step of that directive.
- R4: For a spatial directive, element p starts at base + p*offset. The base grows by offset*cfgPeCount per step of that directive, which folds the dimension over time.
- R5: Directive 0 is the outer loop and directive 1 the inner loop. When the inner directive is at its last position and a tile is accepted, the inner base returns to 0 and the outer base takes one step.
- R6: A directive is at its last position when base + advance >= dimension length. The run therefore contains ceil(L0/A0)*ceil(L1/A1) tiles, where Ld is the length of directive d's dimension and Ad is its per-step advance.
- R7: An element's end index on a dimension is min(start + size - 1, length - 1).
- R8: Element p is valid only if p < cfgPeCount and both of its start indices lie below their dimension lengths. A non-valid element drives all six ranges as 0, and `peValid` is all zero whenever `tileValid` is low.
- R9: For a valid element, inLo = outLo + filtLo and inHi = outHi + filtHi, each one bit wider than an index.
- R10: The schedule advances only on a cycle where `tileValid` and `stepReady` are both high. Otherwise every tile output holds its value.
- R11: `tileDone` is high for exactly one cycle, the cycle after the final tile is accepted, with `tileValid` low. The block is idle and accepts `start` on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run; sampled only while idle |
| cfgKind | input | 2 | Per-directive kind, 1 = spatial |
| cfgDim | input | 2 | Per-directive dimension, 1 = output, 0 = filter |
| cfgSize | input | 2*IDX_W | Per-directive points per element |
| cfgOffset | input | 2*IDX_W | Per-directive offset |
| cfgFiltLen | input | IDX_W | Filter dimension length |
| cfgOutLen | input | IDX_W | Output dimension length |
| cfgPeCount | input | PE_W | Number of active elements |
| stepReady | input | 1 | Consumer takes the current tile |
| tileValid | output | 1 | A tile is presented |
| tileDone | output | 1 | One-cycle end-of-run flag |
| peValid | output | NUM_PE | Per-element valid |
| filtLo | output | NUM_PE*IDX_W | Per-element filter start |
| filtHi | output | NUM_PE*IDX_W | Per-element filter end |
| outLo | output | NUM_PE*IDX_W | Per-element output start |
| outHi | output | NUM_PE*IDX_W | Per-element output end |
| inLo | output | NUM_PE*(IDX_W+1) | Per-element input start |
| inHi | output | NUM_PE*(IDX_W+1) | Per-element input end |

## Verification
The bench builds the block with NUM_PE = 4 and IDX_W = 10. Four elements are few enough that short dimensions already force spatial folding, clipping at the far end and elements whose start falls past the dimension. The 10-bit indices keep the random lengths far from wrap-around while still exercising the wider input sum. Random directive kinds, dimension assignments and element counts from 1 to 4 cover both loop orders and both stationary styles, and the directed three-element weight-stationary case pins the expected schedule exactly.

// File: rtl/maptile_pkg.sv
package maptile_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } tileState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;       // capture configuration, clear both bases
    logic stepInner;  // advance inner directive
    logic stepOuter;  // wrap inner directive, advance outer directive
    logic active;     // a tile is currently presented
  } tileStrobe_t;

endpackage

// File: rtl/maptile_span.sv
module maptile_span #(
  parameter int IDX_W  = 16,
  parameter int PE_W   = 4,
  parameter int PE_IDX = 0
) (
  input  logic [IDX_W-1:0] base,
  input  logic             spatial,
  input  logic [IDX_W-1:0] size,
  input  logic [IDX_W-1:0] off,
  input  logic [IDX_W-1:0] len,
  output logic [IDX_W-1:0] lo,
  output logic [IDX_W-1:0] hi,
  output logic             inRange
);
  localparam int EXT_W = IDX_W + PE_W + 2;
  localparam logic [EXT_W-1:0] PE_K = EXT_W'(PE_IDX);

  logic [EXT_W-1:0] shiftX;
  logic [EXT_W-1:0] startX;
  logic [EXT_W-1:0] endX;
  logic [EXT_W-1:0] lastX;

  always_comb begin
    shiftX  = spatial ? (PE_K * EXT_W'(off)) : '0;
    startX  = EXT_W'(base) + shiftX;
    endX    = startX + EXT_W'(size) - EXT_W'(1);
    lastX   = EXT_W'(len) - EXT_W'(1);
    inRange = (startX < EXT_W'(len));
    lo      = startX[IDX_W-1:0];
    hi      = (endX > lastX) ? lastX[IDX_W-1:0] : endX[IDX_W-1:0];
  end

endmodule

// File: rtl/maptile_ctrl.sv
module maptile_ctrl
  import maptile_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        stepReady,
  input  logic        lastInner,
  input  logic        lastOuter,
  output tileStrobe_t strobe,
  output logic        tileValid,
  output logic        tileDone
);
  tileState_t state, stateNext;
  logic accept;
  logic finalTile;

  always_comb begin
    accept    = (state == ST_RUN) && stepReady;
    finalTile = lastInner && lastOuter;
    strobe    = '0;
    strobe.load   = (state == ST_IDLE) && start;
    strobe.active = (state == ST_RUN);
    if (accept && !finalTile) begin
      if (lastInner) strobe.stepOuter = 1'b1;
      else           strobe.stepInner = 1'b1;
    end
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (start) stateNext = ST_RUN;
      ST_RUN:  if (accept && finalTile) stateNext = ST_DONE;
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign tileValid = (state == ST_RUN);
  assign tileDone  = (state == ST_DONE);

endmodule

// File: rtl/maptile_dp.sv
module maptile_dp
  import maptile_pkg::*;
#(
  parameter int IDX_W  = 16,
  parameter int NUM_PE = 8,
  parameter int PE_W   = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  tileStrobe_t                 strobe,
  input  logic [1:0]                  cfgKind,
  input  logic [1:0]                  cfgDim,
  input  logic [2*IDX_W-1:0]          cfgSize,
  input  logic [2*IDX_W-1:0]          cfgOffset,
  input  logic [IDX_W-1:0]            cfgFiltLen,
  input  logic [IDX_W-1:0]            cfgOutLen,
  input  logic [PE_W-1:0]             cfgPeCount,
  output logic                        lastInner,
  output logic                        lastOuter,
  output logic [NUM_PE-1:0]           peValid,
  output logic [NUM_PE*IDX_W-1:0]     filtLo,
  output logic [NUM_PE*IDX_W-1:0]     filtHi,
  output logic [NUM_PE*IDX_W-1:0]     outLo,
  output logic [NUM_PE*IDX_W-1:0]     outHi,
  output logic [NUM_PE*(IDX_W+1)-1:0] inLo,
  output logic [NUM_PE*(IDX_W+1)-1:0] inHi
);
  localparam int EXT_W = IDX_W + PE_W + 2;
  localparam int IN_W  = IDX_W + 1;

  logic [1:0]       kindR;
  logic [1:0]       dimR;
  logic [IDX_W-1:0] sizeR [2];
  logic [IDX_W-1:0] offR  [2];
  logic [IDX_W-1:0] baseR [2];
  logic [IDX_W-1:0] lenF;
  logic [IDX_W-1:0] lenO;
  logic [PE_W-1:0]  peCnt;

  logic [EXT_W-1:0] adv    [2];
  logic [IDX_W-1:0] dimLen [2];
  logic [1:0]       atLast;

  // per-directive advance and last-position detection
  for (genvar d = 0; d < 2; d++) begin : g_dir
    always_comb begin
      adv[d]    = kindR[d] ? (EXT_W'(offR[d]) * EXT_W'(peCnt)) : EXT_W'(offR[d]);
      dimLen[d] = dimR[d] ? lenO : lenF;
      atLast[d] = (EXT_W'(baseR[d]) + adv[d]) >= EXT_W'(dimLen[d]);
    end
  end

  assign lastOuter = atLast[0];
  assign lastInner = atLast[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kindR <= '0;
      dimR  <= '0;
      lenF  <= '0;
      lenO  <= '0;
      peCnt <= '0;
      for (int d = 0; d < 2; d++) begin
        sizeR[d] <= '0;
        offR[d]  <= '0;
        baseR[d] <= '0;
      end
    end else if (strobe.load) begin
      kindR <= cfgKind;
      dimR  <= cfgDim;
      lenF  <= cfgFiltLen;
      lenO  <= cfgOutLen;
      peCnt <= cfgPeCount;
      for (int d = 0; d < 2; d++) begin
        sizeR[d] <= cfgSize[d*IDX_W +: IDX_W];
        offR[d]  <= cfgOffset[d*IDX_W +: IDX_W];
        baseR[d] <= '0;
      end
    end else if (strobe.stepOuter) begin
      baseR[0] <= baseR[0] + adv[0][IDX_W-1:0];
      baseR[1] <= '0;
    end else if (strobe.stepInner) begin
      baseR[1] <= baseR[1] + adv[1][IDX_W-1:0];
    end
  end

  // which directive drives each dimension
  logic fSel;
  logic oSel;
  assign fSel = dimR[0];
  assign oSel = ~dimR[0];

  logic [IDX_W-1:0] fBase, oBase, fSize, oSize, fOff, oOff;
  logic             fKind, oKind;

  always_comb begin
    fBase = baseR[fSel];
    oBase = baseR[oSel];
    fSize = sizeR[fSel];
    oSize = sizeR[oSel];
    fOff  = offR[fSel];
    oOff  = offR[oSel];
    fKind = kindR[fSel];
    oKind = kindR[oSel];
  end

  for (genvar p = 0; p < NUM_PE; p++) begin : g_pe
    logic [IDX_W-1:0] fLoRaw, fHiRaw, oLoRaw, oHiRaw;
    logic             fIn, oIn, ok;

    maptile_span #(.IDX_W(IDX_W), .PE_W(PE_W), .PE_IDX(p)) u_filt (
      .base(fBase), .spatial(fKind), .size(fSize), .off(fOff), .len(lenF),
      .lo(fLoRaw), .hi(fHiRaw), .inRange(fIn)
    );

    maptile_span #(.IDX_W(IDX_W), .PE_W(PE_W), .PE_IDX(p)) u_out (
      .base(oBase), .spatial(oKind), .size(oSize), .off(oOff), .len(lenO),
      .lo(oLoRaw), .hi(oHiRaw), .inRange(oIn)
    );

    always_comb begin
      ok = strobe.active && (peCnt > PE_W'(p)) && fIn && oIn;
      peValid[p] = ok;
      filtLo[p*IDX_W +: IDX_W] = ok ? fLoRaw : '0;
      filtHi[p*IDX_W +: IDX_W] = ok ? fHiRaw : '0;
      outLo[p*IDX_W +: IDX_W]  = ok ? oLoRaw : '0;
      outHi[p*IDX_W +: IDX_W]  = ok ? oHiRaw : '0;
      inLo[p*IN_W +: IN_W]     = ok ? (IN_W'(oLoRaw) + IN_W'(fLoRaw)) : '0;
      inHi[p*IN_W +: IN_W]     = ok ? (IN_W'(oHiRaw) + IN_W'(fHiRaw)) : '0;
    end
  end

endmodule

// File: rtl/maptile_gen.sv
module maptile_gen
  import maptile_pkg::*;
#(
  parameter int  NUM_PE = 8,
  parameter int  IDX_W  = 16,
  localparam int PE_W   = $clog2(NUM_PE + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  input  logic [1:0]                  cfgKind,
  input  logic [1:0]                  cfgDim,
  input  logic [2*IDX_W-1:0]          cfgSize,
  input  logic [2*IDX_W-1:0]          cfgOffset,
  input  logic [IDX_W-1:0]            cfgFiltLen,
  input  logic [IDX_W-1:0]            cfgOutLen,
  input  logic [PE_W-1:0]             cfgPeCount,
  input  logic                        stepReady,
  output logic                        tileValid,
  output logic                        tileDone,
  output logic [NUM_PE-1:0]           peValid,
  output logic [NUM_PE*IDX_W-1:0]     filtLo,
  output logic [NUM_PE*IDX_W-1:0]     filtHi,
  output logic [NUM_PE*IDX_W-1:0]     outLo,
  output logic [NUM_PE*IDX_W-1:0]     outHi,
  output logic [NUM_PE*(IDX_W+1)-1:0] inLo,
  output logic [NUM_PE*(IDX_W+1)-1:0] inHi
);
  tileStrobe_t strobe;
  logic lastInner;
  logic lastOuter;

  maptile_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .stepReady(stepReady),
    .lastInner(lastInner), .lastOuter(lastOuter),
    .strobe(strobe), .tileValid(tileValid), .tileDone(tileDone)
  );

  maptile_dp #(.IDX_W(IDX_W), .NUM_PE(NUM_PE), .PE_W(PE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cfgKind(cfgKind), .cfgDim(cfgDim), .cfgSize(cfgSize), .cfgOffset(cfgOffset),
    .cfgFiltLen(cfgFiltLen), .cfgOutLen(cfgOutLen), .cfgPeCount(cfgPeCount),
    .lastInner(lastInner), .lastOuter(lastOuter),
    .peValid(peValid), .filtLo(filtLo), .filtHi(filtHi),
    .outLo(outLo), .outHi(outHi), .inLo(inLo), .inHi(inHi)
  );

endmodule

// File: rtl/maptile_gen_chk.sv
module maptile_gen_chk #(
  parameter int  NUM_PE = 8,
  parameter int  IDX_W  = 16,
  localparam int PE_W   = $clog2(NUM_PE + 1)
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        start,
  input logic [1:0]                  cfgKind,
  input logic [1:0]                  cfgDim,
  input logic [2*IDX_W-1:0]          cfgSize,
  input logic [2*IDX_W-1:0]          cfgOffset,
  input logic [IDX_W-1:0]            cfgFiltLen,
  input logic [IDX_W-1:0]            cfgOutLen,
  input logic [PE_W-1:0]             cfgPeCount,
  input logic                        stepReady,
  input logic                        tileValid,
  input logic                        tileDone,
  input logic [NUM_PE-1:0]           peValid,
  input logic [NUM_PE*IDX_W-1:0]     filtLo,
  input logic [NUM_PE*IDX_W-1:0]     filtHi,
  input logic [NUM_PE*IDX_W-1:0]     outLo,
  input logic [NUM_PE*IDX_W-1:0]     outHi,
  input logic [NUM_PE*(IDX_W+1)-1:0] inLo,
  input logic [NUM_PE*(IDX_W+1)-1:0] inHi
);
  localparam int IN_W = IDX_W + 1;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    tileDone |=> !tileDone); // R11

  AST_DONE_NOT_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !(tileDone && tileValid)); // R11

  AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tileDone) |-> $past(tileValid && stepReady)); // R11

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (tileValid && !stepReady) |=> (tileValid && $stable(filtLo) && $stable(outLo)
                                   && $stable(peValid))); // R10

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !tileValid |-> (peValid == '0)); // R8

  for (genvar p = 0; p < NUM_PE; p++) begin : g_chk
    AST_END_NOT_BEFORE_START: assert property (@(posedge clk) disable iff (!rstN)
      peValid[p] |-> (filtHi[p*IDX_W +: IDX_W] >= filtLo[p*IDX_W +: IDX_W])
                  && (outHi[p*IDX_W +: IDX_W] >= outLo[p*IDX_W +: IDX_W])); // R7

    AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      !peValid[p] |-> (filtLo[p*IDX_W +: IDX_W] == '0) && (filtHi[p*IDX_W +: IDX_W] == '0)
                   && (outLo[p*IDX_W +: IDX_W] == '0) && (outHi[p*IDX_W +: IDX_W] == '0)
                   && (inLo[p*IN_W +: IN_W] == '0) && (inHi[p*IN_W +: IN_W] == '0)); // R8

    AST_INPUT_SPAN_ORDER: assert property (@(posedge clk) disable iff (!rstN)
      peValid[p] |-> (inHi[p*IN_W +: IN_W] >= inLo[p*IN_W +: IN_W])); // R9
  end

endmodule

bind maptile_gen maptile_gen_chk #(.NUM_PE(NUM_PE), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/maptile_gen_bench.sv
module maptile_gen_bench;
  localparam int NUM_PE = 4;
  localparam int IDX_W  = 10;
  localparam int PE_W   = $clog2(NUM_PE + 1);
  localparam int IN_W   = IDX_W + 1;

  logic                        clk = 1'b0;
  logic                        rstN = 1'b0;
  logic                        start = 1'b0;
  logic [1:0]                  cfgKind = '0;
  logic [1:0]                  cfgDim = '0;
  logic [2*IDX_W-1:0]          cfgSize = '0;
  logic [2*IDX_W-1:0]          cfgOffset = '0;
  logic [IDX_W-1:0]            cfgFiltLen = '0;
  logic [IDX_W-1:0]            cfgOutLen = '0;
  logic [PE_W-1:0]             cfgPeCount = '0;
  logic                        stepReady = 1'b0;
  logic                        tileValid, tileDone;
  logic [NUM_PE-1:0]           peValid;
  logic [NUM_PE*IDX_W-1:0]     filtLo, filtHi, outLo, outHi;
  logic [NUM_PE*IN_W-1:0]      inLo, inHi;

  always #4 clk = ~clk;

  maptile_gen #(.NUM_PE(NUM_PE), .IDX_W(IDX_W)) u_maptile_gen (.*);

  int nRun = 0;
  int nFail = 0;

  // bench model of the loop nest
  int mKind[2], mDim[2], mSize[2], mOff[2], mBase[2];
  int mLenF, mLenO, mPe;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int advOf(int d);
    return (mKind[d] != 0) ? mOff[d] * mPe : mOff[d];
  endfunction

  function automatic int lenOf(int d);
    return (mDim[d] != 0) ? mLenO : mLenF;
  endfunction

  function automatic bit isLast(int d);
    return (mBase[d] + advOf(d)) >= lenOf(d);
  endfunction

  function automatic int startOf(int d, int p);
    return mBase[d] + ((mKind[d] != 0) ? p * mOff[d] : 0);
  endfunction

  function automatic int endOf(int d, int p);
    int e;
    e = startOf(d, p) + mSize[d] - 1;
    return (e > lenOf(d) - 1) ? lenOf(d) - 1 : e;
  endfunction

  function automatic int ceilDiv(int a, int b);
    return (a + b - 1) / b;
  endfunction

  task automatic checkTile();
    int fd, od;
    fd = (mDim[0] == 0) ? 0 : 1;
    od = 1 - fd;
    for (int p = 0; p < NUM_PE; p++) begin
      int sf, so, ef, eo;
      bit v;
      string kt;
      sf = startOf(fd, p);
      so = startOf(od, p);
      v  = (p < mPe) && (sf < mLenF) && (so < mLenO);
      ef = v ? endOf(fd, p) : 0;
      eo = v ? endOf(od, p) : 0;
      if (!v) begin sf = 0; so = 0; end
      check(peValid[p] == v, "R8", $sformatf("peValid[%0d]", p), peValid[p], v);
      kt = (mKind[fd] != 0) ? "R4" : "R3";
      check(filtLo[p*IDX_W +: IDX_W] == sf, kt, $sformatf("filtLo[%0d]", p),
            filtLo[p*IDX_W +: IDX_W], sf);
      kt = (mKind[od] != 0) ? "R4" : "R3";
      check(outLo[p*IDX_W +: IDX_W] == so, kt, $sformatf("outLo[%0d]", p),
            outLo[p*IDX_W +: IDX_W], so);
      check(filtHi[p*IDX_W +: IDX_W] == ef, "R7", $sformatf("filtHi[%0d]", p),
            filtHi[p*IDX_W +: IDX_W], ef);
      check(outHi[p*IDX_W +: IDX_W] == eo, "R7", $sformatf("outHi[%0d]", p),
            outHi[p*IDX_W +: IDX_W], eo);
      check(inLo[p*IN_W +: IN_W] == sf + so, "R9", $sformatf("inLo[%0d]", p),
            inLo[p*IN_W +: IN_W], sf + so);
      check(inHi[p*IN_W +: IN_W] == ef + eo, "R9", $sformatf("inHi[%0d]", p),
            inHi[p*IN_W +: IN_W], ef + eo);
    end
  endtask

  task automatic runConfig(input int k0, input int k1, input int d0,
                           input int s0, input int s1, input int o0, input int o1,
                           input int lf, input int lo, input int pe,
                           input int stallPct, input bit poke);
    int tiles, expTiles, d1;
    bit finalAcc, wrap;
    d1 = 1 - d0;
    mKind[0] = k0; mKind[1] = k1; mDim[0] = d0; mDim[1] = d1;
    mSize[0] = s0; mSize[1] = s1; mOff[0] = o0; mOff[1] = o1;
    mLenF = lf; mLenO = lo; mPe = pe; mBase[0] = 0; mBase[1] = 0;
    expTiles = ceilDiv(lenOf(0), advOf(0)) * ceilDiv(lenOf(1), advOf(1));
    cfgKind    = {k1[0], k0[0]};
    cfgDim     = {d1[0], d0[0]};
    cfgSize    = {IDX_W'(s1), IDX_W'(s0)};
    cfgOffset  = {IDX_W'(o1), IDX_W'(o0)};
    cfgFiltLen = IDX_W'(lf);
    cfgOutLen  = IDX_W'(lo);
    cfgPeCount = PE_W'(pe);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(tileValid == 1'b1, "R2", "tileValid after start", tileValid, 1);
    tiles = 0;
    while (tileValid) begin
      checkTile();
      if (poke && tiles == 1) begin
        // R2: start and new configuration while running must be ignored
        cfgFiltLen = IDX_W'(lf + 7);
        cfgOutLen  = IDX_W'(lo + 5);
        cfgPeCount = PE_W'(1);
        cfgKind    = ~cfgKind;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(tileValid == 1'b1, "R2", "still running after start poke", tileValid, 1);
        check(outLo[0 +: IDX_W] == startOf((mDim[0] == 0) ? 1 : 0, 0), "R2",
              "PE0 outLo after start poke", outLo[0 +: IDX_W],
              startOf((mDim[0] == 0) ? 1 : 0, 0));
        checkTile();
      end
      if (($urandom % 100) < stallPct) begin
        logic [NUM_PE*IDX_W-1:0] snapF, snapO;
        logic [NUM_PE-1:0] snapV;
        snapF = filtLo; snapO = outLo; snapV = peValid;
        stepReady = 1'b0;
        @(negedge clk);
        check(tileValid && filtLo == snapF && outLo == snapO && peValid == snapV,
              "R10", "tile held while stalled", longint'(outLo), longint'(snapO));
      end else begin
        finalAcc = isLast(0) && isLast(1);
        wrap = isLast(1);
        stepReady = 1'b1;
        @(negedge clk);
        stepReady = 1'b0;
        tiles++;
        if (finalAcc) break;
        if (wrap) begin
          mBase[1] = 0;
          mBase[0] = mBase[0] + advOf(0);
          check(((mDim[1] != 0) ? outLo[0 +: IDX_W] : filtLo[0 +: IDX_W]) == 0, "R5",
                "inner base wrapped to 0", (mDim[1] != 0) ? outLo[0 +: IDX_W] : filtLo[0 +: IDX_W], 0);
          check(((mDim[0] != 0) ? outLo[0 +: IDX_W] : filtLo[0 +: IDX_W]) == mBase[0], "R5",
                "outer base stepped", (mDim[0] != 0) ? outLo[0 +: IDX_W] : filtLo[0 +: IDX_W], mBase[0]);
        end else begin
          mBase[1] = mBase[1] + advOf(1);
        end
      end
    end
    check(tiles == expTiles, "R6", "tile count", tiles, expTiles);
    check(tileDone == 1'b1 && tileValid == 1'b0, "R11", "done after final accept",
          {tileDone, tileValid}, 2);
    check(peValid == '0, "R8", "peValid quiet at done", peValid, 0);
    @(negedge clk);
    check(tileDone == 1'b0, "R11", "done lasts one cycle", tileDone, 0);
  endtask

  initial begin
    void'($urandom(32'd4021));
    @(negedge clk);
    check(tileValid == 0 && tileDone == 0 && peValid == '0, "R1", "outputs in reset",
          {tileValid, tileDone, peValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(tileValid == 0 && tileDone == 0 && peValid == '0, "R1", "outputs after reset",
          {tileValid, tileDone, peValid}, 0);

    // weight-stationary: filter spatial (size 1, off 1) outer, output temporal (size 3, off 3) inner
    runConfig(1, 0, 0, 1, 3, 1, 3, 3, 6, 3, 0, 1'b1);
    // filter folds over time: 5 taps on 3 elements, output clipped at end
    runConfig(1, 0, 0, 1, 3, 1, 3, 5, 7, 3, 30, 1'b0);
    // output-stationary order: output temporal outer, filter spatial inner
    runConfig(0, 1, 1, 2, 1, 2, 1, 6, 5, 4, 20, 1'b0);
    // single-point dimensions
    runConfig(0, 0, 0, 1, 1, 1, 1, 1, 1, 1, 0, 1'b0);
    // overlapping windows, size larger than offset
    runConfig(1, 1, 1, 4, 3, 2, 1, 9, 10, 2, 25, 1'b0);

    for (int n = 0; n < 30; n++) begin
      runConfig($urandom % 2, $urandom % 2, $urandom % 2,
                1 + $urandom % 4, 1 + $urandom % 4, 1 + $urandom % 4, 1 + $urandom % 4,
                1 + $urandom % 24, 1 + $urandom % 24, 1 + $urandom % NUM_PE,
                25, 1'b0);
    end

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nRun++;
    nFail++;
    $display("FAIL watchdog: run did not finish actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule